// File: doc/BRIEF.md
# Quadword access splitting sequencer

This block takes one 128-bit (quadword) load or store and turns it into two 64-bit (doubleword) memory beats, issued one after the other. It accepts six forms of the operation: plain load, prefixed load, plain store, prefixed store, load-and-reserve and store-conditional. With each request it receives the effective address, an endian-mode flag and the number of an even/odd register pair. For each beat it presents the address, the register of the pair that the beat uses, a store flag and a beat index.

The order of the register pair depends on both the endian mode and the form. Some forms must be quadword aligned, and for them a misaligned address does not start any beat. Instead the block raises an alignment exception pulse. The alignment check is done in the cycle the request is accepted. The downstream memory stage may stall a beat. When it completes the first beat it may also abort the operation, and the second beat is then never issued.

Top module: `qword_split_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, req_ready is 1, beat_valid is 0 and align_exc is 0.
- R2: A non-trapping operation issues exactly two beats, with beat_idx 0 and then 1. The first beat's address equals req_ea. The second beat's address equals the first plus 8, taken modulo 2^64.
- R3: A load-and-reserve (kind 4) or store-conditional (kind 5) whose req_ea[3:0] is not zero raises align_exc for exactly one cycle, the cycle after it is accepted, in either endian mode. It issues no beat.
- R4: A plain load (kind 0) with req_ea[3:0] not zero traps as in R3 when req_le is 1, and issues its two beats normally when req_le is 0.
- R5: Bit 0 of req_reg is ignored; E denotes req_reg with bit 0 cleared. For kinds 0, 2, 4 and 5 with req_le=1, the first beat carries E+1 and the second carries E. In every other case the first beat carries E and the second carries E+1.
- R6: beat_store is 1 for the kinds plain store (2), prefixed store (3) and store-conditional (5), and 0 for plain load (0), prefixed load (1) and load-and-reserve (4).
- R7: req_ready falls in the cycle after an accept. It stays 0 until the cycle after the last beat handshake, the exception pulse or the abort, and then it returns to 1.
- R8: If beat_abort is 1 while the first beat completes (beat_valid=1, beat_ready=1, beat_idx=0), no second beat follows and req_ready is 1 in the next cycle.
- R9: While beat_valid is 1 and beat_ready is 0, beat_valid, beat_idx, beat_addr, beat_reg and beat_store hold their values into the next cycle.
- R10: A prefixed load (kind 1) never raises align_exc, whatever its address and endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 3 | Form: 0 load, 1 prefixed load, 2 store, 3 prefixed store, 4 load-and-reserve, 5 store-conditional |
| req_ea | input | 64 | Effective address |
| req_le | input | 1 | 1 = little-endian mode |
| req_reg | input | 5 | Register pair number (bit 0 ignored) |
| beat_valid | output | 1 | A doubleword beat is presented |
| beat_ready | input | 1 | Memory stage takes the beat |
| beat_abort | input | 1 | With the first beat's handshake: drop the second beat |
| beat_addr | output | 64 | Beat address |
| beat_reg | output | 5 | Register used by this beat |
| beat_store | output | 1 | 1 = store beat |
| beat_idx | output | 1 | Beat index, 0 or 1 |
| align_exc | output | 1 | One-cycle alignment exception pulse |

## Verification
The first beat's completion and an abort can arrive in the same cycle. The block must then choose between stepping to the second beat and returning to idle. The bench provokes this by raising beat_abort exactly in the cycle it raises beat_ready for beat 0, sometimes after several stall cycles. It judges the result by checking in the next cycle that beat_valid is 0 and req_ready is 1, and that the next operation starts cleanly with beat index 0.

// File: rtl/qws_pkg.sv
package qws_pkg;

  typedef enum logic [2:0] {
    QK_LOAD      = 3'd0,
    QK_LOAD_PFX  = 3'd1,
    QK_STORE     = 3'd2,
    QK_STORE_PFX = 3'd3,
    QK_LOAD_RSV  = 3'd4,
    QK_STORE_CND = 3'd5
  } qk_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_TRAP  = 2'd1,
    S_BEAT0 = 2'd2,
    S_BEAT1 = 2'd3
  } qws_state_e;

endpackage

// File: rtl/qws_decode.sv
module qws_decode
  import qws_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic [2:0]        kind,
  input  logic              le,
  input  logic [ADDR_W-1:0] ea,
  output logic              trap,
  output logic              swap,
  output logic              is_store
);

  function automatic logic misaligned(input logic [ADDR_W-1:0] a);
    return a[ALIGN_BITS-1:0] != '0;
  endfunction

  // forms that must be aligned; plain load only in little-endian mode
  function automatic logic must_align(input logic [2:0] k, input logic l);
    case (k)
      QK_LOAD_RSV, QK_STORE_CND: return 1'b1;
      QK_LOAD:                   return l;
      default:                   return 1'b0;
    endcase
  endfunction

  // prefixed forms keep the natural order in both modes
  function automatic logic odd_first(input logic [2:0] k, input logic l);
    case (k)
      QK_LOAD, QK_STORE, QK_LOAD_RSV, QK_STORE_CND: return l;
      default:                                      return 1'b0;
    endcase
  endfunction

  function automatic logic store_form(input logic [2:0] k);
    case (k)
      QK_STORE, QK_STORE_PFX, QK_STORE_CND: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction

  always_comb begin
    trap     = must_align(kind, le) && misaligned(ea);
    swap     = odd_first(kind, le);
    is_store = store_form(kind);
  end

endmodule

// File: rtl/qws_beat_gen.sv
module qws_beat_gen #(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 5,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] ea_in,
  input  logic [REG_W-1:0]  reg_in,
  input  logic              swap_in,
  input  logic              store_in,
  input  logic              idx,
  input  logic              stall,
  input  logic              step,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [REG_W-1:0]  beat_reg,
  output logic              beat_store
);

  logic [ADDR_W-1:0] ea_q;
  logic [REG_W-1:0]  reg_q;
  logic              swap_q;
  logic              store_q;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [ADDR_W-1:0] base,
                                                input logic            second);
    return second ? base + ADDR_W'(STEP) : base;
  endfunction

  function automatic logic [REG_W-1:0] reg_of(input logic [REG_W-1:0] base,
                                              input logic           sw,
                                              input logic           second);
    return (base & ~REG_W'(1)) | REG_W'(sw ^ second);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q    <= '0;
      reg_q   <= '0;
      swap_q  <= 1'b0;
      store_q <= 1'b0;
    end else if (capture) begin
      ea_q    <= ea_in;
      reg_q   <= reg_in;
      swap_q  <= swap_in;
      store_q <= store_in;
    end
  end

  always_comb begin
    beat_addr  = addr_of(ea_q, idx);
    beat_reg   = reg_of(reg_q, swap_q, idx);
    beat_store = store_q;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> beat_addr == $past(beat_addr) + ADDR_W'(STEP)); // R2

  AST_REG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> beat_reg == ($past(beat_reg) ^ REG_W'(1))); // R5

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(beat_addr) && $stable(beat_reg) && $stable(beat_store)); // R9

endmodule

// File: rtl/qws_ctrl.sv
module qws_ctrl
  import qws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic trap,
  input  logic beat_ready,
  input  logic beat_abort,
  output logic req_ready,
  output logic accept,
  output logic beat_valid,
  output logic beat_idx,
  output logic align_exc,
  output logic stall,
  output logic step
);

  qws_state_e state, state_nx;
  logic       first_done;
  logic       abort_hit;

  always_comb begin
    req_ready  = state == S_IDLE;
    accept     = req_valid && req_ready;
    beat_valid = state == S_BEAT0 || state == S_BEAT1;
    beat_idx   = state == S_BEAT1;
    align_exc  = state == S_TRAP;
    stall      = beat_valid && !beat_ready;
    first_done = state == S_BEAT0 && beat_ready;
    abort_hit  = first_done && beat_abort;
    step       = first_done && !beat_abort;
  end

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (req_valid) state_nx = trap ? S_TRAP : S_BEAT0;
      S_TRAP:  state_nx = S_IDLE;
      S_BEAT0: if (beat_ready) state_nx = beat_abort ? S_IDLE : S_BEAT1;
      S_BEAT1: if (beat_ready) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7

  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    align_exc |=> !align_exc && req_ready); // R3

  AST_EXC_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    align_exc |-> !beat_valid); // R3

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> beat_valid && beat_idx); // R2

  AST_ABORT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> !beat_valid && req_ready); // R8

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> beat_valid && $stable(beat_idx)); // R9

endmodule

// File: rtl/qword_split_seq.sv
module qword_split_seq
  import qws_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic              req_le,
  input  logic [REG_W-1:0]  req_reg,
  output logic              beat_valid,
  input  logic              beat_ready,
  input  logic              beat_abort,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [REG_W-1:0]  beat_reg,
  output logic              beat_store,
  output logic              beat_idx,
  output logic              align_exc
);

  localparam int STEP = 1 << (ALIGN_BITS - 1);

  logic dec_trap, dec_swap, dec_store;
  logic accept, stall, step;

  qws_decode #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_decode (
    .kind     (req_kind),
    .le       (req_le),
    .ea       (req_ea),
    .trap     (dec_trap),
    .swap     (dec_swap),
    .is_store (dec_store)
  );

  qws_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .trap       (dec_trap),
    .beat_ready (beat_ready),
    .beat_abort (beat_abort),
    .req_ready  (req_ready),
    .accept     (accept),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .align_exc  (align_exc),
    .stall      (stall),
    .step       (step)
  );

  qws_beat_gen #(.ADDR_W(ADDR_W), .REG_W(REG_W), .STEP(STEP)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept),
    .ea_in      (req_ea),
    .reg_in     (req_reg),
    .swap_in    (dec_swap),
    .store_in   (dec_store),
    .idx        (beat_idx),
    .stall      (stall),
    .step       (step),
    .beat_addr  (beat_addr),
    .beat_reg   (beat_reg),
    .beat_store (beat_store)
  );

  AST_PFX_LOAD_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == QK_LOAD_PFX) |=> !align_exc && beat_valid); // R10

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_trap) |=> beat_valid && !beat_idx && beat_addr == $past(req_ea)); // R2

endmodule

// File: tb/qword_split_seq_tb_top.sv
`timescale 1ns/1ps
module qword_split_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [63:0] req_ea = '0;
  logic        req_le = 1'b0;
  logic [4:0]  req_reg = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic        beat_abort = 1'b0;
  logic [63:0] beat_addr;
  logic [4:0]  beat_reg;
  logic        beat_store;
  logic        beat_idx;
  logic        align_exc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qword_split_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_ea(req_ea), .req_le(req_le), .req_reg(req_reg),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_abort(beat_abort),
    .beat_addr(beat_addr), .beat_reg(beat_reg), .beat_store(beat_store),
    .beat_idx(beat_idx), .align_exc(align_exc)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expectations written from the requirements
  function automatic bit exp_trap(input int k, input bit le, input logic [63:0] ea);
    bit odd_low = (ea % 16) != 0;
    if (!odd_low) return 0;
    if (k == 4 || k == 5) return 1;
    if (k == 0 && le) return 1;
    return 0;
  endfunction

  function automatic bit exp_store(input int k);
    return (k == 2) || (k == 3) || (k == 5);
  endfunction

  function automatic logic [4:0] exp_reg(input int k, input bit le, input logic [4:0] r, input int beat);
    int even = (r / 2) * 2;
    bit swapped = le && (k != 1) && (k != 3);
    int first  = swapped ? even + 1 : even;
    int second = swapped ? even : even + 1;
    return (beat == 0) ? 5'(first) : 5'(second);
  endfunction

  task automatic run_op(input int k, input logic [63:0] ea, input bit le,
                        input logic [4:0] rg, input bit abort, input int st0, input int st1);
    @(negedge clk);
    check("R7 ready before accept", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_kind = 3'(k); req_ea = ea; req_le = le; req_reg = rg;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 ready low after accept", 64'(req_ready), 64'd0);
    if (exp_trap(k, le, ea)) begin
      check(k == 0 ? "R4 exc pulse" : "R3 exc pulse", 64'(align_exc), 64'd1);
      check("R3 no beat on trap", 64'(beat_valid), 64'd0);
      @(negedge clk);
      check("R3 exc one cycle", 64'(align_exc), 64'd0);
      check("R3 no beat after trap", 64'(beat_valid), 64'd0);
      check("R7 ready after trap", 64'(req_ready), 64'd1);
      return;
    end
    check(k == 1 ? "R10 prefixed load no exc" : "R4 no exc", 64'(align_exc), 64'd0);
    for (int s = 0; s <= st0; s++) begin
      check(s > 0 ? "R9 beat0 held valid" : "R2 beat0 valid", 64'(beat_valid), 64'd1);
      check("R2 beat0 idx", 64'(beat_idx), 64'd0);
      check("R2 beat0 addr", beat_addr, ea);
      check("R5 beat0 reg", 64'(beat_reg), 64'(exp_reg(k, le, rg, 0)));
      check("R6 beat0 store", 64'(beat_store), 64'(exp_store(k)));
      check("R7 busy beat0", 64'(req_ready), 64'd0);
      beat_ready = (s == st0);
      beat_abort = abort && (s == st0);
      @(negedge clk);
    end
    beat_ready = 1'b0; beat_abort = 1'b0;
    if (abort) begin
      check("R8 no second beat", 64'(beat_valid), 64'd0);
      check("R8 ready after abort", 64'(req_ready), 64'd1);
      return;
    end
    for (int s = 0; s <= st1; s++) begin
      check(s > 0 ? "R9 beat1 held valid" : "R2 beat1 valid", 64'(beat_valid), 64'd1);
      check("R2 beat1 idx", 64'(beat_idx), 64'd1);
      check("R2 beat1 addr", beat_addr, ea + 64'd8);
      check("R5 beat1 reg", 64'(beat_reg), 64'(exp_reg(k, le, rg, 1)));
      check("R6 beat1 store", 64'(beat_store), 64'(exp_store(k)));
      check("R7 busy beat1", 64'(req_ready), 64'd0);
      beat_ready = (s == st1);
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check("R2 only two beats", 64'(beat_valid), 64'd0);
    check("R7 ready after beats", 64'(req_ready), 64'd1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b1e));
    repeat (3) @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset valid", 64'(beat_valid), 64'd0);
    check("R1 reset exc", 64'(align_exc), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset ready", 64'(req_ready), 64'd1);
    check("R1 post-reset valid", 64'(beat_valid), 64'd0);
    check("R1 post-reset exc", 64'(align_exc), 64'd0);

    // directed: every form, both modes, aligned and misaligned
    for (int k = 0; k < 6; k++)
      for (int le = 0; le < 2; le++) begin
        run_op(k, 64'h0000_1000_0000_2340, le[0], 5'd6, 1'b0, 0, 0);
        run_op(k, 64'h0000_1000_0000_2348, le[0], 5'd7, 1'b0, 1, 2);
      end
    // address wrap on the second beat
    run_op(2, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 5'd30, 1'b0, 0, 0);
    // abort coinciding with first-beat completion, with and without stall
    run_op(3, 64'h40, 1'b1, 5'd2, 1'b1, 0, 0);
    run_op(0, 64'h80, 1'b1, 5'd4, 1'b1, 3, 0);
    run_op(5, 64'h90, 1'b0, 5'd8, 1'b0, 0, 0);

    for (int n = 0; n < 300; n++) begin
      int k = int'($urandom % 6);
      logic [63:0] ea = {$urandom, $urandom};
      if ($urandom % 2) ea[3:0] = 4'h0;
      run_op(k, ea, 1'($urandom), 5'($urandom), ($urandom % 5) == 0,
             int'($urandom % 3), int'($urandom % 3));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule